// File: doc/BRIEF.md
# Flash Status Register Controller

This block holds the status byte and read-source selection for a 16-bit flash command interface. A command decoder in front of it presents one decoded 8-bit code per cycle. A write state machine behind it reports completion, pass or fail, and suspend acknowledgement. The block keeps the ready, suspend, fail, protect and sleep bits. It chooses whether a read cycle returns array data, identifier data or the status word. It freezes the status word for the length of each read cycle. It refuses new program or erase work while a failure is still unacknowledged.

A read cycle is active while both chip enable and output enable are low. Status is captured at the clock edge where the later of the two strobes has gone low, and it stays frozen until either strobe goes high again. Program, erase, suspend and abort requests are passed to the write state machine as one-cycle pulses.

Top module: `flash_stat_ctl`

## Requirements
- R1: After reset the status byte reads 0x80 (ready set; suspend, both fail bits and sleep clear), bit 3 excepted, and the read source is the array.
- R2: A status read returns ready on bit 7, erase-suspended on bit 6, erase-failed on bit 5, program-failed on bit 4, sector-protect on bit 3 and sleep on bit 2. Bits 1:0 and 15:8 are zero.
- R3: `rd_data` is zero unless both strobes are low and were also low at the previous clock edge. Status is captured at the edge where the later strobe is first seen low, and it is held until a strobe rises.
- R4: Program (0x40) or erase (0x20), issued while the device is ready, not suspended, not asleep and with no fail bit set, gives a one-cycle `wsm_start` in the next cycle. `wsm_erase` is 1 for erase. Ready then reads 0.
- R5: `wsm_done` sets ready and clears erase-suspended. If `wsm_fail` is also high, it sets the erase-fail bit for an erase or the program-fail bit for a program.
- R6: The fail bits stay set through every other command and are cleared only by clear-status (0x50). Clear-status does not change bits 7, 3 or 2.
- R7: Program or erase issued while either fail bit is set gives a one-cycle `cmd_reject` and no `wsm_start`, and the status byte stays unchanged.
- R8: Bit 3 always equals `prot_in`.
- R9: Command 0xFF selects array reads, 0x70 selects status reads and 0x90 selects ID reads. Program and erase also select status reads. Clear-status leaves the source unchanged.
- R10: Sleep (0xC0) while ready sets bit 2 in the next cycle and selects status reads. While busy, sleep takes effect when `wsm_done` arrives. Once a suspend has been issued, sleep is ignored.
- R11: The sleep bit is cleared only by read-array (0xFF).
- R12: `abort_req` while an operation is busy gives a one-cycle `wsm_abort` pulse and sets bit 2. While ready, it has no effect.
- R13: Suspend (0xB0) during a busy erase gives a one-cycle `wsm_suspend` pulse. `wsm_susp_ack` then sets bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | Command code valid this cycle |
| cmd_code | input | 8 | Command code |
| abort_req | input | 1 | Abort request |
| wsm_done | input | 1 | Write state machine finished or resumed-and-finished |
| wsm_fail | input | 1 | Qualifies `wsm_done` as a failure |
| wsm_susp_ack | input | 1 | Write state machine reached suspend |
| prot_in | input | 1 | Sector-protect state |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | DATA_W | Array read data |
| id_data | input | DATA_W | Identifier read data |
| rd_data | output | DATA_W | Read data bus |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 ID |
| wsm_start | output | 1 | Start pulse to the write state machine |
| wsm_erase | output | 1 | Operation kind: 1 erase, 0 program |
| wsm_suspend | output | 1 | Suspend request pulse |
| wsm_abort | output | 1 | Abort request pulse |
| cmd_reject | output | 1 | Program or erase refused |
| sleep_flag | output | 1 | Sleep bit |

## Verification
The bench builds the block with DATA_W at 16 and LATCH_STATUS at 1, so the read port captures status on the strobe edge rather than passing it through. That setting makes the hold window observable: the bench changes status in the middle of a read cycle and lowers the two strobes at different times. A 16-bit bus also makes the zero upper byte visible, next to distinct array and ID patterns.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OP_RD_ARRAY = 8'hFF;
   localparam logic [CMD_W-1:0] OP_RD_STAT  = 8'h70;
   localparam logic [CMD_W-1:0] OP_RD_ID    = 8'h90;
   localparam logic [CMD_W-1:0] OP_CLR_STAT = 8'h50;
   localparam logic [CMD_W-1:0] OP_SLEEP    = 8'hC0;
   localparam logic [CMD_W-1:0] OP_SUSPEND  = 8'hB0;
   localparam logic [CMD_W-1:0] OP_PROGRAM  = 8'h40;
   localparam logic [CMD_W-1:0] OP_ERASE    = 8'h20;

   localparam int STAT_W = 8;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_ID     = 2'd2
   } rd_src_e;

   typedef struct packed {
      logic rd_arr;
      logic rd_stat;
      logic rd_id;
      logic clr;
      logic slp;
      logic sus;
      logic prg;
      logic ers;
   } cmd_hit_t;
endpackage

// File: rtl/fsc_cmd_dec.sv
module fsc_cmd_dec
   import fsc_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] cmd_code,
   output cmd_hit_t          hit
);
   if (CODE_W != CMD_W) begin : g_bad_code_w
      $error("fsc_cmd_dec: CODE_W must equal CMD_W");
   end

   always_comb begin
      hit = '0;
      if (cmd_valid) begin
         unique case (cmd_code)
            OP_RD_ARRAY: hit.rd_arr  = 1'b1;
            OP_RD_STAT:  hit.rd_stat = 1'b1;
            OP_RD_ID:    hit.rd_id   = 1'b1;
            OP_CLR_STAT: hit.clr     = 1'b1;
            OP_SLEEP:    hit.slp     = 1'b1;
            OP_SUSPEND:  hit.sus     = 1'b1;
            OP_PROGRAM:  hit.prg     = 1'b1;
            OP_ERASE:    hit.ers     = 1'b1;
            default:     hit         = '0;
         endcase
      end
   end
endmodule

// File: rtl/fsc_stat_core.sv
module fsc_stat_core
   import fsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_hit_t          hit,
   input  logic              abort_req,
   input  logic              wsm_done,
   input  logic              wsm_fail,
   input  logic              wsm_susp_ack,
   input  logic              prot_in,
   output logic [STAT_W-1:0] stat,
   output rd_src_e           src,
   output logic              start_p,
   output logic              op_erase,
   output logic              susp_p,
   output logic              abort_p,
   output logic              reject_p,
   output logic              sleep_o
);
   logic ready, esusp, efail, pfail, sleep_b;
   logic susp_iss, sleep_pend;
   logic any_fail, may_start;

   assign any_fail  = efail | pfail;
   assign may_start = ready & ~esusp & ~sleep_b & ~any_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready      <= 1'b1;
         esusp      <= 1'b0;
         efail      <= 1'b0;
         pfail      <= 1'b0;
         sleep_b    <= 1'b0;
         op_erase   <= 1'b0;
         susp_iss   <= 1'b0;
         sleep_pend <= 1'b0;
         src        <= SRC_ARRAY;
         start_p    <= 1'b0;
         susp_p     <= 1'b0;
         abort_p    <= 1'b0;
         reject_p   <= 1'b0;
      end else begin
         start_p  <= 1'b0;
         susp_p   <= 1'b0;
         abort_p  <= 1'b0;
         reject_p <= 1'b0;

         // write state machine events
         if (wsm_done) begin
            ready    <= 1'b1;
            esusp    <= 1'b0;
            susp_iss <= 1'b0;
            if (wsm_fail) begin
               if (op_erase) efail <= 1'b1;
               else          pfail <= 1'b1;
            end
            if (sleep_pend) begin
               sleep_b    <= 1'b1;
               sleep_pend <= 1'b0;
               src        <= SRC_STATUS;
            end
         end
         if (wsm_susp_ack && susp_iss) begin
            esusp <= 1'b1;
            ready <= 1'b1;
         end
         if (abort_req && !ready) begin
            sleep_b <= 1'b1;
            abort_p <= 1'b1;
         end

         // decoded commands
         if (hit.rd_arr) begin
            src        <= SRC_ARRAY;
            sleep_b    <= 1'b0;
            sleep_pend <= 1'b0;
         end
         if (hit.rd_stat) src <= SRC_STATUS;
         if (hit.rd_id)   src <= SRC_ID;
         if (hit.clr) begin
            efail <= 1'b0;
            pfail <= 1'b0;
         end
         if (hit.prg || hit.ers) begin
            src <= SRC_STATUS;
            if (any_fail) begin
               reject_p <= 1'b1;
            end else if (may_start) begin
               start_p  <= 1'b1;
               ready    <= 1'b0;
               op_erase <= hit.ers;
            end
         end
         if (hit.sus && !ready && op_erase && !susp_iss) begin
            susp_iss <= 1'b1;
            susp_p   <= 1'b1;
         end
         if (hit.slp && !susp_iss && !esusp) begin
            if (ready) begin
               sleep_b <= 1'b1;
               src     <= SRC_STATUS;
            end else begin
               sleep_pend <= 1'b1;
            end
         end
      end
   end

   assign stat    = {ready, esusp, efail, pfail, prot_in, sleep_b, 2'b00};
   assign sleep_o = sleep_b;
endmodule

// File: rtl/fsc_rd_port.sv
module fsc_rd_port
   import fsc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit LATCH_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  rd_src_e           src,
   input  logic [STAT_W-1:0] stat,
   input  logic [DATA_W-1:0] array_data,
   input  logic [DATA_W-1:0] id_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PAD_W = DATA_W - STAT_W;

   logic              strobe, strobe_q;
   logic [STAT_W-1:0] lat;
   logic [DATA_W-1:0] stat_word;

   assign strobe = ~ce_n & ~oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   if (LATCH_STATUS) begin : g_capture
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 lat <= '0;
         else if (strobe && !strobe_q) lat <= stat;
      end
   end else begin : g_transparent
      always_comb lat = stat;
   end

   assign stat_word = {{PAD_W{1'b0}}, lat};

   always_comb begin
      rd_data = '0;
      if (strobe && strobe_q) begin
         unique case (src)
            SRC_ARRAY:  rd_data = array_data;
            SRC_STATUS: rd_data = stat_word;
            SRC_ID:     rd_data = id_data;
            default:    rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/flash_stat_ctl.sv
module flash_stat_ctl
   import fsc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit LATCH_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic              abort_req,
   input  logic              wsm_done,
   input  logic              wsm_fail,
   input  logic              wsm_susp_ack,
   input  logic              prot_in,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] array_data,
   input  logic [DATA_W-1:0] id_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_src,
   output logic              wsm_start,
   output logic              wsm_erase,
   output logic              wsm_suspend,
   output logic              wsm_abort,
   output logic              cmd_reject,
   output logic              sleep_flag
);
   if (DATA_W <= STAT_W) begin : g_bad_data_w
      $error("flash_stat_ctl: DATA_W must exceed the status byte width");
   end

   cmd_hit_t          hit;
   logic [STAT_W-1:0] stat_w;
   rd_src_e           src_w;

   fsc_cmd_dec #(.CODE_W(8)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .hit       (hit)
   );

   fsc_stat_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (hit),
      .abort_req    (abort_req),
      .wsm_done     (wsm_done),
      .wsm_fail     (wsm_fail),
      .wsm_susp_ack (wsm_susp_ack),
      .prot_in      (prot_in),
      .stat         (stat_w),
      .src          (src_w),
      .start_p      (wsm_start),
      .op_erase     (wsm_erase),
      .susp_p       (wsm_suspend),
      .abort_p      (wsm_abort),
      .reject_p     (cmd_reject),
      .sleep_o      (sleep_flag)
   );

   fsc_rd_port #(.DATA_W(DATA_W), .LATCH_STATUS(LATCH_STATUS)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .src        (src_w),
      .stat       (stat_w),
      .array_data (array_data),
      .id_data    (id_data),
      .rd_data    (rd_data)
   );

   assign rd_src = src_w;
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic              ce_n,
   input logic              oe_n,
   input logic              wsm_done,
   input logic              wsm_susp_ack,
   input logic              wsm_start,
   input logic              cmd_reject,
   input logic [7:0]        stat_w,
   input logic [1:0]        rd_src,
   input logic [DATA_W-1:0] rd_data
);
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stat_w[5]) || $fell(stat_w[4])) |-> $past(cmd_valid && cmd_code == 8'h50)); // R6
   AST_START_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      wsm_start |-> ($past(stat_w[5:4]) == 2'b00)); // R7
   AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> !wsm_start); // R7
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wsm_start |=> !wsm_start); // R4
   AST_SLEEP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_w[2]) |-> $past(cmd_valid && cmd_code == 8'hFF)); // R11
   AST_READY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_w[7]) |-> $past(wsm_done || wsm_susp_ack)); // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && $past(!ce_n && !oe_n) && $past(!ce_n && !oe_n, 2)
       && rd_src == 2'd1 && $past(rd_src) == 2'd1) |-> $stable(rd_data)); // R3
endmodule

bind flash_stat_ctl fsc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_code     (cmd_code),
   .ce_n         (ce_n),
   .oe_n         (oe_n),
   .wsm_done     (wsm_done),
   .wsm_susp_ack (wsm_susp_ack),
   .wsm_start    (wsm_start),
   .cmd_reject   (cmd_reject),
   .stat_w       (stat_w),
   .rd_src       (rd_src),
   .rd_data      (rd_data)
);

// File: tb/sim_flash_stat_ctl.sv
module sim_flash_stat_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam logic [DW-1:0] ARR = 16'hA5C3;
   localparam logic [DW-1:0] IDV = 16'h1234;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_code = 8'h00;
   logic          abort_req = 1'b0;
   logic          wsm_done = 1'b0;
   logic          wsm_fail = 1'b0;
   logic          wsm_susp_ack = 1'b0;
   logic          prot_in = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [DW-1:0] rd_data;
   logic [1:0]    rd_src;
   logic          wsm_start, wsm_erase, wsm_suspend, wsm_abort, cmd_reject, sleep_flag;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic p_start, p_rej, p_susp, p_erase, p_abort;
   logic [DW-1:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_stat_ctl #(.DATA_W(DW), .LATCH_STATUS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .abort_req(abort_req), .wsm_done(wsm_done), .wsm_fail(wsm_fail),
      .wsm_susp_ack(wsm_susp_ack), .prot_in(prot_in), .ce_n(ce_n), .oe_n(oe_n),
      .array_data(ARR), .id_data(IDV), .rd_data(rd_data), .rd_src(rd_src),
      .wsm_start(wsm_start), .wsm_erase(wsm_erase), .wsm_suspend(wsm_suspend),
      .wsm_abort(wsm_abort), .cmd_reject(cmd_reject), .sleep_flag(sleep_flag)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] c);
      cmd_valid = 1'b1;
      cmd_code  = c;
      @(negedge clk);
      p_start = wsm_start; p_rej = cmd_reject; p_susp = wsm_suspend; p_erase = wsm_erase;
      cmd_valid = 1'b0;
   endtask

   task automatic wsm_end(input logic fail);
      wsm_done = 1'b1; wsm_fail = fail;
      @(negedge clk);
      wsm_done = 1'b0; wsm_fail = 1'b0;
   endtask

   task automatic do_abort();
      abort_req = 1'b1;
      @(negedge clk);
      p_abort = wsm_abort;
      abort_req = 1'b0;
   endtask

   task automatic rd_word(output logic [DW-1:0] r);
      ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      r = rd_data;
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd_stat(output logic [DW-1:0] r);
      cmd(8'h70);
      rd_word(r);
   endtask

   task automatic t_reset();
      chk("R1 source after reset", {14'd0, rd_src}, 16'd0);
      rd_word(v); chk("R9 array read", v, ARR);
      rd_stat(v); chk("R1 R2 status after reset", v, 16'h0080);
      prot_in = 1'b1; @(negedge clk);
      rd_word(v); chk("R8 protect bit", v, 16'h0088);
      prot_in = 1'b0; @(negedge clk);
      chk("R3 idle bus zero", rd_data, 16'h0000);
      cmd(8'h90); rd_word(v); chk("R9 id read", v, IDV);
   endtask

   task automatic t_program_pass();
      cmd(8'h40);
      chk("R4 start pulse", {15'd0, p_start}, 16'd1);
      chk("R4 program kind", {15'd0, p_erase}, 16'd0);
      rd_word(v); chk("R4 R9 busy status", v, 16'h0000);
      wsm_end(1'b0);
      rd_word(v); chk("R5 ready after done", v, 16'h0080);
   endtask

   task automatic t_fail_lock();
      cmd(8'h20);
      chk("R4 erase kind", {14'd0, p_start, p_erase}, 16'd3);
      wsm_end(1'b1);
      rd_word(v); chk("R5 erase fail bit", v, 16'h00A0);
      cmd(8'h40);
      chk("R7 reject pulse", {14'd0, p_rej, p_start}, 16'd2);
      rd_word(v); chk("R7 status unchanged", v, 16'h00A0);
      cmd(8'hFF); rd_word(v); chk("R9 back to array", v, ARR);
      rd_stat(v); chk("R6 fail sticky", v, 16'h00A0);
      cmd(8'h50); rd_word(v); chk("R6 clear status", v, 16'h0080);
      cmd(8'h40); wsm_end(1'b1);
      rd_word(v); chk("R5 program fail bit", v, 16'h0090);
      cmd(8'h20); chk("R7 erase refused", {14'd0, p_rej, p_start}, 16'd2);
      cmd(8'h50); rd_word(v); chk("R6 cleared again", v, 16'h0080);
   endtask

   task automatic t_latch();
      cmd(8'h40);
      ce_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R3 one strobe only", rd_data, 16'h0000);
      wsm_end(1'b0);
      oe_n = 1'b0;
      @(negedge clk);
      chk("R3 capture on later strobe", rd_data, 16'h0080);
      cmd(8'h40);
      @(negedge clk);
      chk("R3 held during read", rd_data, 16'h0080);
      oe_n = 1'b1; @(negedge clk);
      oe_n = 1'b0; @(negedge clk);
      chk("R3 new value after toggle", rd_data, 16'h0000);
      ce_n = 1'b1; oe_n = 1'b1; @(negedge clk);
      wsm_end(1'b0);
   endtask

   task automatic t_suspend();
      cmd(8'h20);
      cmd(8'hB0);
      chk("R13 suspend pulse", {15'd0, p_susp}, 16'd1);
      wsm_susp_ack = 1'b1; @(negedge clk); wsm_susp_ack = 1'b0;
      rd_word(v); chk("R13 suspended status", v, 16'h00C0);
      cmd(8'hC0);
      rd_word(v); chk("R10 sleep ignored after suspend", v, 16'h00C0);
      wsm_end(1'b0);
      rd_word(v); chk("R5 suspend cleared by done", v, 16'h0080);
   endtask

   task automatic t_sleep();
      cmd(8'hFF);
      cmd(8'hC0);
      chk("R10 sleep flag", {15'd0, sleep_flag}, 16'd1);
      rd_word(v); chk("R10 sleep status source", v, 16'h0084);
      cmd(8'h50); rd_stat(v); chk("R11 sleep survives clear", v, 16'h0084);
      cmd(8'h40); chk("R4 no start while asleep", {15'd0, p_start}, 16'd0);
      cmd(8'hFF); rd_stat(v); chk("R11 read array wakes", v, 16'h0080);
      cmd(8'h40); cmd(8'hC0);
      rd_word(v); chk("R10 sleep deferred while busy", v, 16'h0000);
      cmd(8'h90);
      wsm_end(1'b0);
      rd_word(v); chk("R10 sleep after done", v, 16'h0084);
      cmd(8'hFF);
   endtask

   task automatic t_abort();
      do_abort();
      chk("R12 abort ignored when ready", {15'd0, p_abort}, 16'd0);
      rd_stat(v); chk("R12 status unchanged", v, 16'h0080);
      cmd(8'h40);
      do_abort();
      chk("R12 abort pulse", {15'd0, p_abort}, 16'd1);
      rd_word(v); chk("R12 abort sets sleep bit", v, 16'h0004);
      wsm_end(1'b0);
      rd_word(v); chk("R12 abort then done", v, 16'h0084);
      cmd(8'hFF); rd_stat(v); chk("R11 cleared after abort", v, 16'h0080);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_pass();
      t_fail_lock();
      t_latch();
      t_suspend();
      t_sleep();
      t_abort();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule